// File: doc/BRIEF.md
# Program and Erase Sequencer with Write Protection

This block carries out the memory-modifying instructions of a serial non-volatile memory: single-word write, single-word erase, erase of the whole array and write of one word into the whole array. A serial front end decodes each frame and hands over a one-cycle command strobe together with the address and data it collected. The sequencer keeps that request pending. When chip select falls, it starts a self-timed cycle that needs no further serial clocking.

Two independent guards protect the array. The first is a software enable latch, set and cleared by its own pair of instructions. The second is a hardware program-enable pin. A modifying request runs only if both allow it. A counter of system clocks stands in for the program pulse. While that counter runs, the block raises busy and drives a single-word write port into the array. A single-word write first stores all ones into the target word and then stores the data, so no erase is needed beforehand.

Top module: `prog_erase_seq`

## Requirements
- R1: The enable latch `wel` is 0 after reset. An idle-time enable strobe sets it and an idle-time disable strobe clears it, whatever the level of `prog_en`.
- R2: A pending request starts only if `wel` is 1 and `prog_en` is 1 in the cycle `cs_fall` is seen. Otherwise it is dropped: busy never rises and the array port stays idle.
- R3: A permitted request starts on `cs_fall` and not on the strobe. `busy` rises one clock after `cs_fall` and stays high for exactly `CYC_CLKS` clocks. The array port writes only while `busy` is high.
- R4: An erase leaves the addressed word all ones.
- R5: A single-word write to an address first writes all ones to that address, then writes the data, and the word ends holding the data.
- R6: Erase-all leaves every word all ones.
- R7: Write-all leaves every word holding the given data.
- R8: Strobes and `cs_fall` that arrive while `busy` is high are ignored. They change neither `wel` nor any pending request, and they start no new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_write | input | 1 | Single-word write request strobe |
| stb_erase | input | 1 | Single-word erase request strobe |
| stb_erall | input | 1 | Erase-whole-array request strobe |
| stb_wrall | input | 1 | Write-whole-array request strobe |
| stb_ewen | input | 1 | Set-enable-latch strobe |
| stb_ewds | input | 1 | Clear-enable-latch strobe |
| cmd_addr | input | ADDR_W | Word address carried with the strobe |
| cmd_data | input | DATA_W | Data word carried with the strobe |
| prog_en | input | 1 | Hardware program-enable pin |
| cs_fall | input | 1 | One-cycle pulse marking the chip-select falling edge |
| busy | output | 1 | High while a program or erase cycle runs |
| wel | output | 1 | State of the software enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that the front end raises at most one strobe per cycle. They also assume that `cs_fall` is a single-cycle pulse and that `CYC_CLKS` is at least twice the array depth, so the clear sweep and the store sweep both fit inside the busy window. The stimulus drives every strobe and every `cs_fall` for exactly one clock, one at a time, and keeps the default cycle length of 40 clocks over 16 words. Protection cases hold the request pending and change only the latch or the pin before the chip-select pulse.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ERASE = 2'd1,
    OP_ERALL = 2'd2,
    OP_WRALL = 2'd3
  } op_e;

  // operation needs an all-ones pass before (or instead of) storing
  function automatic logic op_clears(op_e op);
    return op != OP_WRALL;
  endfunction

  // operation stores the carried data word
  function automatic logic op_stores(op_e op);
    return (op == OP_WRITE) || (op == OP_WRALL);
  endfunction

  // operation walks every address instead of one
  function automatic logic op_sweeps(op_e op);
    return (op == OP_ERALL) || (op == OP_WRALL);
  endfunction

  // one-hot modifying strobes to an operation code
  function automatic op_e op_from_strobes(logic s_wr, logic s_er, logic s_ea, logic s_wa);
    op_e r;
    r = OP_WRITE;
    if (s_er) r = OP_ERASE;
    if (s_ea) r = OP_ERALL;
    if (s_wa) r = OP_WRALL;
    if (s_wr) r = OP_WRITE;
    return r;
  endfunction
endpackage

// File: rtl/pes_wel.sv
module pes_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
    else if (clr_i) wel_o <= 1'b0;
  end
endmodule

// File: rtl/pes_frame.sv
module pes_frame
  import pes_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              consume_i,
  output logic              vld_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      op_o   <= OP_WRITE;
      addr_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      op_o   <= op_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (consume_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pes_engine.sv
module pes_engine
  import pes_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CYC_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              clr_win_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(CYC_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(CYC_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(CYC_CLKS / 2);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  tick_q;
  logic [CNT_W-1:0]  span;
  logic [CNT_W-1:0]  offs;
  logic              sto_win;

  function automatic logic in_win(logic [CNT_W-1:0] t, logic [CNT_W-1:0] base,
                                  logic [CNT_W-1:0] len);
    return (t >= base) && (t < base + len);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      tick_q <= '0;
      op_q   <= OP_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      tick_q <= '0;
      op_q   <= op_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (busy_o) begin
      if (tick_q == LAST_C) busy_o <= 1'b0;
      else                  tick_q <= tick_q + 1'b1;
    end
  end

  always_comb begin
    span        = op_sweeps(op_q) ? DEPTH_C : CNT_W'(1);
    clr_win_o   = busy_o && op_clears(op_q) && in_win(tick_q, '0, span);
    sto_win     = busy_o && op_stores(op_q) && in_win(tick_q, HALF_C, span);
    offs        = clr_win_o ? tick_q : tick_q - HALF_C;
    arr_we_o    = clr_win_o || sto_win;
    arr_addr_o  = op_sweeps(op_q) ? offs[ADDR_W-1:0] : addr_q;
    arr_wdata_o = clr_win_o ? '1 : data_q;
  end
endmodule

// File: rtl/prog_erase_seq.sv
module prog_erase_seq
  import pes_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CYC_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_write,
  input  logic              stb_erase,
  input  logic              stb_erall,
  input  logic              stb_wrall,
  input  logic              stb_ewen,
  input  logic              stb_ewds,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              prog_en,
  input  logic              cs_fall,
  output logic              busy,
  output logic              wel,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic              idle;
  logic              mod_stb;
  logic              pend_vld;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              consume;
  logic              allowed;
  logic              start;
  logic              clr_win;

  assign idle    = !busy;
  assign mod_stb = stb_write || stb_erase || stb_erall || stb_wrall;
  assign consume = idle && cs_fall;
  assign allowed = wel && prog_en;
  assign start   = consume && pend_vld && allowed;

  pes_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (idle && stb_ewen),
    .clr_i (idle && stb_ewds),
    .wel_o (wel)
  );

  pes_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (idle && mod_stb),
    .op_i      (op_from_strobes(stb_write, stb_erase, stb_erall, stb_wrall)),
    .addr_i    (cmd_addr),
    .data_i    (cmd_data),
    .consume_i (consume),
    .vld_o     (pend_vld),
    .op_o      (pend_op),
    .addr_o    (pend_addr),
    .data_o    (pend_data)
  );

  pes_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (pend_op),
    .addr_i      (pend_addr),
    .data_i      (pend_data),
    .busy_o      (busy),
    .clr_win_o   (clr_win),
    .arr_we_o    (arr_we),
    .arr_addr_o  (arr_addr),
    .arr_wdata_o (arr_wdata)
  );
endmodule

// File: rtl/prog_erase_seq_chk.sv
module prog_erase_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_ewen,
  input logic              stb_ewds,
  input logic              prog_en,
  input logic              cs_fall,
  input logic              busy,
  input logic              wel,
  input logic              arr_we,
  input logic [DATA_W-1:0] arr_wdata,
  input logic              start,
  input logic              clr_win
);
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_ewen && !busy) |=> wel); // R1
  AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_ewds && !stb_ewen && !busy) |=> !wel); // R1
  AST_BLOCKED_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !busy && !(wel && prog_en)) |=> !busy); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R3
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_win |-> (arr_we && arr_wdata == '1)); // R5
  AST_BUSY_FREEZES_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wel)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
endmodule

bind prog_erase_seq prog_erase_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stb_ewen  (stb_ewen),
  .stb_ewds  (stb_ewds),
  .prog_en   (prog_en),
  .cs_fall   (cs_fall),
  .busy      (busy),
  .wel       (wel),
  .arr_we    (arr_we),
  .arr_wdata (arr_wdata),
  .start     (start),
  .clr_win   (clr_win)
);

// File: tb/prog_erase_seq_test.sv
module prog_erase_seq_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int CYC = 40;
  localparam logic [DW-1:0] ONES = '1;

  typedef struct {
    string         req;
    int            addr;
    logic [DW-1:0] val;
    bit            all;
    bit            want_clear;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    stb = '0;   // 0 write,1 erase,2 erall,3 wrall,4 ewen,5 ewds
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          prog_en = 1'b0;
  logic          cs_fall = 1'b0;
  logic          busy, wel, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  logic [DW-1:0] arr [DEPTH];
  item_t         sbq [$];
  int            total = 0;
  int            bad = 0;
  int            we_cnt = 0;
  int            busy_cyc = 0;
  int            run_len = 0;
  bit            prev_busy = 0;
  bit            got_first = 0;
  logic [DW-1:0] first_val = '0;

  always #10 clk = ~clk;

  prog_erase_seq #(.ADDR_W(AW), .DATA_W(DW), .CYC_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n),
    .stb_write(stb[0]), .stb_erase(stb[1]), .stb_erall(stb[2]),
    .stb_wrall(stb[3]), .stb_ewen(stb[4]), .stb_ewds(stb[5]),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prog_en(prog_en),
    .cs_fall(cs_fall), .busy(busy), .wel(wel), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  // array model fed by the write port
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (arr_we) begin
      arr[arr_addr] <= arr_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a busy period ends
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we) begin
        we_cnt++;
        if (sbq.size() > 0 && !got_first && int'(arr_addr) == sbq[0].addr) begin
          got_first = 1;
          first_val = arr_wdata;
        end
      end
      if (busy) begin
        busy_cyc++;
        run_len++;
      end else if (prev_busy) begin
        if (sbq.size() == 0) begin
          chk("R8 unexpected cycle", 1, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk({it.req, " busy length"}, run_len, CYC);
          if (it.all) begin
            for (int i = 0; i < DEPTH; i++) chk({it.req, " word"}, arr[i], it.val);
          end else begin
            chk({it.req, " word"}, arr[it.addr], it.val);
          end
          if (it.want_clear) chk({it.req, " clear first"}, first_val, ONES);
        end
        run_len = 0;
        got_first = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic strobe(int idx, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    stb[idx] = 1'b1;
    cmd_addr = a;
    cmd_data = d;
    @(negedge clk);
    stb = '0;
  endtask

  task automatic pulse_cs();
    @(negedge clk);
    cs_fall = 1'b1;
    @(negedge clk);
    cs_fall = 1'b0;
  endtask

  task automatic expect_run(string req, int a, logic [DW-1:0] v, bit all, bit clr);
    item_t it;
    it.req = req; it.addr = a; it.val = v; it.all = all; it.want_clear = clr;
    sbq.push_back(it);
  endtask

  task automatic settle();
    repeat (CYC + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int we0, by0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset wel", wel, 0);
    chk("R3 reset busy", busy, 0);
    chk("R3 reset we", arr_we, 0);

    // R2: latch clear blocks a write
    we0 = we_cnt; by0 = busy_cyc;
    prog_en = 1'b1;
    strobe(0, 4'd1, 16'h1111);
    pulse_cs();
    repeat (10) @(negedge clk);
    chk("R2 latch off no busy", busy_cyc, by0);
    chk("R2 latch off no write", we_cnt, we0);

    // R1: enable ignores pin level
    prog_en = 1'b0;
    strobe(4, '0, '0);
    chk("R1 enable with pin low", wel, 1);

    // R2: pin low blocks a write
    strobe(0, 4'd1, 16'h2222);
    pulse_cs();
    repeat (10) @(negedge clk);
    chk("R2 pin low no busy", busy_cyc, by0);
    chk("R2 pin low no write", we_cnt, we0);
    chk("R2 pin low word", arr[1], 16'h0000);

    // R3 R5: permitted write with auto clear
    prog_en = 1'b1;
    expect_run("R5 write", 3, 16'hA5A5, 0, 1);
    strobe(0, 4'd3, 16'hA5A5);
    pulse_cs();
    chk("R3 busy after cs fall", busy, 1);
    settle();

    // R3: strobe alone does not start; R4 erase on later cs fall
    strobe(1, 4'd3, '0);
    repeat (60) @(negedge clk);
    chk("R3 no start without cs fall", busy, 0);
    expect_run("R4 erase", 3, ONES, 0, 1);
    pulse_cs();
    settle();

    // R8: strobes and cs fall during busy ignored
    expect_run("R8 first write", 5, 16'h1234, 0, 1);
    strobe(0, 4'd5, 16'h1234);
    pulse_cs();
    repeat (3) @(negedge clk);
    strobe(5, '0, '0);
    strobe(0, 4'd6, 16'h7777);
    pulse_cs();
    settle();
    chk("R8 wel kept", wel, 1);
    chk("R8 word untouched", arr[6], 16'h0000);
    pulse_cs();
    repeat (5) @(negedge clk);
    chk("R8 no stale start", busy, 0);

    // R7 write-all
    expect_run("R7 write all", 0, 16'h5A5A, 1, 0);
    strobe(3, '0, 16'h5A5A);
    pulse_cs();
    settle();

    // R6 erase-all
    expect_run("R6 erase all", 0, ONES, 1, 0);
    strobe(2, '0, '0);
    pulse_cs();
    settle();

    // R1 disable, then R2 blocked
    strobe(5, '0, '0);
    chk("R1 disable clears", wel, 0);
    we0 = we_cnt; by0 = busy_cyc;
    strobe(0, 4'd2, 16'h0000);
    pulse_cs();
    repeat (10) @(negedge clk);
    chk("R2 after disable no write", we_cnt, we0);
    chk("R2 after disable word", arr[2], ONES);
    chk("R2 after disable no busy", busy_cyc, by0);
    chk("R3 scoreboard drained", sbq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule